// File: doc/BRIEF.md
# Asynchronous Bus Slave Data-Phase Handshake Controller

This block runs the second half of a bus cycle for a memory slave on an asynchronous bus. The address has already been captured. The master then raises either a read strobe or a write strobe. The controller opens the RAM output enable or write enable and holds it for a fixed number of clock cycles. It then raises the reply strobe and keeps it up until the master takes its strobe away. On reads it also turns the data transceivers so that they face the bus.

The bus side is asynchronous. The sync, read and write strobes each pass through a synchronizer whose depth is a parameter before the state machine acts on them. The only exception is the transceiver direction: it falls as soon as the raw read strobe falls, so the slave never drives the data lines after the master has let go of them. The decoder supplies a stable "selected" flag, which is low for I/O-page addresses. A deselected access gets no response at all.

Within one sync period the controller accepts one read followed by one write. This is the read-modify-write case. It accepts nothing more until sync falls. Bus init and the fall of sync both return the controller to idle.

Top module: `dphase_ctrl`

## Requirements
- R1: After reset, ram_oe_o, ram_we_o, reply_o and bus_drive_o are all 0.
- R2: With sync_i and sel_i high, a rising din_i (dout_i low) makes ram_oe_o and bus_drive_o go high after the SYNC_STAGES+1'th following rising clock edge; ram_we_o stays 0.
- R3: With sync_i and sel_i high, a rising dout_i (din_i low) makes ram_we_o go high after the SYNC_STAGES+1'th following rising clock edge; ram_oe_o and bus_drive_o stay 0.
- R4: reply_o rises exactly ACCESS_CYCLES clock edges after ram_oe_o or ram_we_o rises, and it is only ever high while one of the two is high.
- R5: reply_o and the active enable stay high while the master's strobe is held. Both fall after the SYNC_STAGES+1'th rising edge after the strobe falls.
- R6: bus_drive_o falls in the same cycle as din_i falls, without waiting for a clock edge.
- R7: While sel_i is low (I/O page), a strobe produces no enable, no reply and no bus drive.
- R8: If din_i and dout_i are both high when an access would start, both are ignored and all outputs stay 0.
- R9: Within one sync period, a completed read may be followed by one write (read-modify-write). A second read after a read is ignored. Any strobe after a write is ignored until sync_i falls.
- R10: When sync_i falls, all outputs are 0 after the SYNC_STAGES+1'th rising edge. When bus_init_i is high, all outputs are 0 after the next rising edge.
- R11: ram_oe_o and ram_we_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_init_i | input | 1 | Bus initialise, synchronous return to idle |
| sync_i | input | 1 | Bus cycle framing from master (async) |
| din_i | input | 1 | Read data strobe from master (async) |
| dout_i | input | 1 | Write data strobe from master (async) |
| sel_i | input | 1 | Decoder flag: 1 = memory space, 0 = I/O page |
| ram_oe_o | output | 1 | RAM output enable, active high |
| ram_we_o | output | 1 | RAM write enable, active high |
| reply_o | output | 1 | Reply strobe to master, active high |
| bus_drive_o | output | 1 | Transceiver direction: 1 = slave drives bus |

## Verification
On every cycle, the assertions check the following:
- the two enables never overlap;
- reply only appears under an enable, and only after exactly the access delay;
- an enable rises only for a selected access;
- reply stays high while the synchronized strobe is held;
- the timer stays in range;
- the sync and init inputs force idle.

Three behaviours can only be shown by the bench's scenarios, because they involve the master's sequence over a whole bus cycle:
- the synchronizer latency, measured edge by edge;
- the bus-drive release with no clock edge between;
- which strobes are accepted or refused in the read-modify-write sequence, and the handling of simultaneous strobes.

// File: rtl/dphase_pkg.sv
`timescale 1ns/1ps
package dphase_pkg;
  typedef enum logic [2:0] {
    HS_IDLE     = 3'd0,
    HS_RD_WAIT  = 3'd1,
    HS_RD_REPLY = 3'd2,
    HS_RD_DONE  = 3'd3,
    HS_WR_WAIT  = 3'd4,
    HS_WR_REPLY = 3'd5,
    HS_SPENT    = 3'd6
  } hs_state_e;

  localparam int unsigned STROBE_N = 3;
  localparam int unsigned IDX_SYNC = 0;
  localparam int unsigned IDX_DIN  = 1;
  localparam int unsigned IDX_DOUT = 2;
endpackage

// File: rtl/dphase_sync.sv
`timescale 1ns/1ps
module dphase_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            stage_q[s] <= '0;
          end else if (s == 0) begin
            stage_q[s] <= d;
          end else begin
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
          end
        end
      end
      assign q = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dphase_timer.sv
`timescale 1ns/1ps
module dphase_timer #(
  parameter int unsigned ACCESS_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = $clog2(ACCESS_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(ACCESS_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || done) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: the count never passes the programmed delay
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(ACCESS_CYCLES));
endmodule

// File: rtl/dphase_fsm.sv
`timescale 1ns/1ps
module dphase_fsm
  import dphase_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic sync_s,
  input  logic din_s,
  input  logic dout_s,
  input  logic sel_i,
  input  logic tmr_done,
  output logic tmr_run,
  output logic oe_o,
  output logic we_o,
  output logic reply_o
);
  hs_state_e state_q, state_d;

  logic rd_req, wr_req;
  assign rd_req = sel_i && din_s && !dout_s;
  assign wr_req = sel_i && dout_s && !din_s;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE:     if (rd_req) state_d = HS_RD_WAIT;
                   else if (wr_req) state_d = HS_WR_WAIT;
      HS_RD_WAIT:  if (tmr_done) state_d = HS_RD_REPLY;
      HS_RD_REPLY: if (!din_s) state_d = HS_RD_DONE;
      HS_RD_DONE:  if (wr_req) state_d = HS_WR_WAIT;
      HS_WR_WAIT:  if (tmr_done) state_d = HS_WR_REPLY;
      HS_WR_REPLY: if (!dout_s) state_d = HS_SPENT;
      HS_SPENT:    state_d = HS_SPENT;
      default:     state_d = HS_IDLE;
    endcase
    if (!sync_s || init_i) state_d = HS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_IDLE;
    else        state_q <= state_d;
  end

  assign tmr_run = (state_q == HS_RD_WAIT) || (state_q == HS_WR_WAIT);
  assign oe_o    = (state_q == HS_RD_WAIT) || (state_q == HS_RD_REPLY);
  assign we_o    = (state_q == HS_WR_WAIT) || (state_q == HS_WR_REPLY);
  assign reply_o = (state_q == HS_RD_REPLY) || (state_q == HS_WR_REPLY);

  p_enable_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(oe_o && we_o));

  p_reply_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reply_o |-> (oe_o || we_o));

  p_selected_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(oe_o) || $rose(we_o)) |-> $past(sel_i));

  p_sync_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_s |=> (!oe_o && !we_o && !reply_o));

  p_init_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (!oe_o && !we_o && !reply_o));

  p_reply_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_o && sync_s && !init_i && ((oe_o && din_s) || (we_o && dout_s))) |=> reply_o);
endmodule

// File: rtl/dphase_ctrl.sv
`timescale 1ns/1ps
module dphase_ctrl
  import dphase_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned ACCESS_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_init_i,
  input  logic sync_i,
  input  logic din_i,
  input  logic dout_i,
  input  logic sel_i,
  output logic ram_oe_o,
  output logic ram_we_o,
  output logic reply_o,
  output logic bus_drive_o
);
  localparam int unsigned AGE_W = $clog2(ACCESS_CYCLES + 2);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [STROBE_N-1:0] raw_strb, syn_strb;
  logic tmr_run, tmr_done;
  logic oe, we, reply;

  assign raw_strb[IDX_SYNC] = sync_i;
  assign raw_strb[IDX_DIN]  = din_i;
  assign raw_strb[IDX_DOUT] = dout_i;

  dphase_sync #(.STAGES(SYNC_STAGES), .WIDTH(STROBE_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_strb), .q(syn_strb)
  );

  dphase_timer #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .done(tmr_done)
  );

  dphase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .init_i(bus_init_i),
    .sync_s(syn_strb[IDX_SYNC]), .din_s(syn_strb[IDX_DIN]),
    .dout_s(syn_strb[IDX_DOUT]), .sel_i(sel_i),
    .tmr_done(tmr_done), .tmr_run(tmr_run),
    .oe_o(oe), .we_o(we), .reply_o(reply)
  );

  assign ram_oe_o    = oe;
  assign ram_we_o    = we;
  assign reply_o     = reply;
  // raw strobe gates the direction so the release needs no clock edge
  assign bus_drive_o = oe && din_i;

  // age of the current enable, used to check the access delay
  logic [AGE_W-1:0] en_age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 en_age_q <= '0;
    else if (!(oe || we))       en_age_q <= '0;
    else if (en_age_q != AGE_MAX) en_age_q <= en_age_q + 1'b1;
  end

  p_access_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reply) |-> (en_age_q == AGE_W'(ACCESS_CYCLES)));

  p_drive_read_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_o |-> !ram_we_o);
endmodule

// File: tb/dphase_ctrl_tb.sv
`timescale 1ns/1ps
module dphase_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STG = 2;
  localparam int DLY = 4;
  localparam int LAT = STG + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_init_i = 1'b0, sync_i = 1'b0, din_i = 1'b0, dout_i = 1'b0, sel_i = 1'b0;
  logic ram_oe_o, ram_we_o, reply_o, bus_drive_o;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dphase_ctrl #(.SYNC_STAGES(STG), .ACCESS_CYCLES(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_init_i(bus_init_i), .sync_i(sync_i),
    .din_i(din_i), .dout_i(dout_i), .sel_i(sel_i),
    .ram_oe_o(ram_oe_o), .ram_we_o(ram_we_o), .reply_o(reply_o),
    .bus_drive_o(bus_drive_o)
  );

  // vector order {oe, we, reply, drive}
  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {ram_oe_o, ram_we_o, reply_o, bus_drive_o};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic open_sync(input logic sel);
    sel_i = sel; sync_i = 1'b1;
    repeat (LAT) @(negedge clk);
  endtask

  task automatic close_sync();
    sync_i = 1'b0;
    repeat (LAT + 1) @(negedge clk);
    chk("R10", 4'b0000);
  endtask

  // one handshake: strobes raised at a negedge, held, then dropped
  task automatic phase(input logic rd, input logic wr, input logic active,
                       input int hold, input string tag);
    logic en, rep, still;
    din_i = rd; dout_i = wr;
    for (int n = 1; n <= LAT + DLY + hold; n++) begin
      @(negedge clk);
      en  = active && (n >= LAT);
      rep = active && (n >= LAT + DLY);
      chk(tag, {en && rd, en && wr, rep, en && rd});
    end
    din_i = 1'b0; dout_i = 1'b0;
    #1;
    chk("R6", {active && rd, active && wr, active, 1'b0});
    for (int n = 1; n <= LAT; n++) begin
      @(negedge clk);
      still = active && (n < LAT);
      chk("R5", {still && rd, still && wr, still, 1'b0});
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    #1; chk("R1", 4'b0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); chk("R1", 4'b0000);

    // sweep selection, strobe kind and hold length
    for (int sel = 0; sel < 2; sel++) begin
      for (int kind = 0; kind < 3; kind++) begin
        for (int hold = 0; hold < 3; hold++) begin
          logic rd, wr, act;
          string tag;
          rd  = (kind != 1);
          wr  = (kind != 0);
          act = (sel == 1) && (kind != 2);
          tag = (sel == 0) ? "R7" : (kind == 2) ? "R8" : (kind == 0) ? "R2" : "R3";
          open_sync(sel[0]);
          phase(rd, wr, act, hold, tag);
          close_sync();
        end
      end
    end

    // read-modify-write, then a refused strobe after the write
    open_sync(1'b1);
    phase(1'b1, 1'b0, 1'b1, 1, "R4");
    phase(1'b0, 1'b1, 1'b1, 1, "R9");
    phase(1'b1, 1'b0, 1'b0, 0, "R9");
    close_sync();

    // second read after read refused, write still accepted
    open_sync(1'b1);
    phase(1'b1, 1'b0, 1'b1, 0, "R2");
    phase(1'b1, 1'b0, 1'b0, 0, "R9");
    phase(1'b0, 1'b1, 1'b1, 0, "R9");
    close_sync();

    // sync withdrawn while the enable is waiting
    open_sync(1'b1);
    din_i = 1'b1;
    repeat (LAT + 1) @(negedge clk);
    chk("R2", 4'b1001);
    sync_i = 1'b0;
    for (int n = 1; n <= LAT; n++) begin
      @(negedge clk);
      chk("R10", (n < LAT) ? 4'b1001 : 4'b0000);
    end
    din_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10", 4'b0000);

    // bus init during a reply
    open_sync(1'b1);
    dout_i = 1'b1;
    repeat (LAT + DLY) @(negedge clk);
    chk("R4", 4'b0110);
    bus_init_i = 1'b1;
    @(negedge clk); chk("R10", 4'b0000);
    dout_i = 1'b0; sync_i = 1'b0;
    repeat (LAT + 1) @(negedge clk);
    bus_init_i = 1'b0;
    @(negedge clk); chk("R10", 4'b0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule